// File: doc/BRIEF.md
# Conversion result FIFO controller

This block sits between a conversion sequencer and the system bus. Each time the sequencer strobes a finished conversion, the block formats the sample and queues it in a small first-in first-out store. The formatting keeps the low 12 bits of the sample. It can optionally narrow the sample to 8 bits, and it can mark a failed conversion with a flag bit. Software or a DMA engine drains the queue through a data register. Each read of that register removes the oldest entry.

A control/status register programs the block and reports the queue state. This includes the fill level, full and empty flags, and sticky overflow and underflow flags, which are cleared by writing 1 to them. The fill level is compared with a programmable threshold. The result drives a DMA request line and a one-bit raw interrupt. The raw interrupt is masked by an enable register and can be forced by a force register to produce the interrupt output.

Registers sit at byte offsets 0x00 (control/status), 0x04 (data), 0x08 (raw interrupt), 0x0C (interrupt enable), 0x10 (interrupt force) and 0x14 (masked interrupt status). Read data appears on `reg_rdata` one clock after the cycle in which `reg_rd` is high.

Top module: `cres_fifo_ctrl`

## Requirements
- R1: After reset the control/status register reads 0x0000_0100 (only empty, bit 8, set), and dma_req and irq are low.
- R2: While enable (control bit 0) is set, each smp_valid pushes the sample masked to its low 12 bits. Data-port reads return entries oldest first in bits 15:0. While enable is clear, strobes push nothing.
- R3: While shift (control bit 1) is set, the stored entry is the 12-bit masked sample shifted right by 4.
- R4: While error tagging (control bit 2) is set and smp_err is high, bit 15 of the stored entry is set. Otherwise bit 15 is 0.
- R5: The queue holds 4 entries. Control/status shows level in bits 19:16, full in bit 9 and empty in bit 8. A strobe arriving while the queue is full is dropped and sets overflow (bit 11).
- R6: Reading the data port while the queue is empty returns 0 and sets underflow (bit 10).
- R7: Writing 1 to bit 10 or bit 11 clears that flag, and writing 0 leaves it unchanged. Enable, shift, tag, DMA enable (bit 3) and threshold (bits 27:24) take the written value.
- R8: The raw interrupt (offset 0x08, bit 0) is high exactly when level >= threshold. A threshold of 0 keeps it high even when the queue is empty.
- R9: irq and the masked status (offset 0x14, bit 0) equal (raw AND enable) OR force. Enable is at offset 0x0C bit 0 and force at offset 0x10 bit 0. Their other bits read 0.
- R10: dma_req is high exactly when DMA enable is set and level >= threshold. It follows every push and pop.
- R11: A push and a pop in the same cycle leave the level unchanged, and the pop returns the oldest entry. A strobe arriving while the queue is full is dropped even if a pop occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Conversion completion strobe |
| smp_data | input | 16 | Raw conversion value |
| smp_err | input | 1 | Conversion reported an error |
| reg_addr | input | 5 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (a data-port read pops an entry) |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted read or write pointer shows at the data port as an entry returned out of order or as a stale value, on the first pop after the fault. A wrong level count appears right away in the level field, and also on dma_req and irq on the very next push or pop that crosses the threshold. A bad full or empty decision shows as a dropped or duplicated sample, or as a spurious overflow or underflow flag, on the next read of the control/status register.

// File: rtl/cres_pkg.sv
package cres_pkg;

   // Register index = byte address bits [4:2]
   typedef enum logic [2:0] {
      RI_CTRL = 3'd0,
      RI_DATA = 3'd1,
      RI_RAW  = 3'd2,
      RI_IEN  = 3'd3,
      RI_IFRC = 3'd4,
      RI_STAT = 3'd5
   } reg_idx_e;

   // Control/status field positions (software decodes these)
   localparam int B_EN    = 0;
   localparam int B_SHIFT = 1;
   localparam int B_TAG   = 2;
   localparam int B_DREQ  = 3;
   localparam int B_EMPTY = 8;
   localparam int B_FULL  = 9;
   localparam int B_UNDER = 10;
   localparam int B_OVER  = 11;
   localparam int B_LVL   = 16;
   localparam int B_THR   = 24;
   localparam int FLD_W   = 4;

   typedef struct packed {
      logic [FLD_W-1:0] thr;
      logic             dreq_en;
      logic             tag_en;
      logic             shift;
      logic             en;
   } cfg_t;

endpackage

// File: rtl/cres_fmt.sv
module cres_fmt #(
   parameter int SMP_W     = 16,
   parameter int RAW_W     = 12,
   parameter int ENT_W     = 16,
   parameter int SHIFT_AMT = 4,
   parameter int TAG_BIT   = 15
) (
   input  logic [SMP_W-1:0] smp,
   input  logic             err,
   input  logic             shift_on,
   input  logic             tag_on,
   output logic [ENT_W-1:0] ent
);

   logic [ENT_W-1:0] base;
   logic [ENT_W-1:0] moved;

   generate
      if (RAW_W > SMP_W) begin : g_chk_raw
         $error("cres_fmt: RAW_W exceeds SMP_W");
      end
      if (TAG_BIT < RAW_W || TAG_BIT >= ENT_W) begin : g_chk_tag
         $error("cres_fmt: TAG_BIT must sit above the sample and inside the entry");
      end
      if (SHIFT_AMT >= RAW_W) begin : g_chk_sh
         $error("cres_fmt: SHIFT_AMT too large");
      end
   endgenerate

   assign base = ENT_W'(smp[RAW_W-1:0]);

   generate
      if (SHIFT_AMT == 0) begin : g_noshift
         assign moved = base;
      end else begin : g_shift
         assign moved = base >> SHIFT_AMT;
      end
      if (SMP_W > RAW_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^smp[SMP_W-1:RAW_W];
      end
   endgenerate

   always_comb begin
      ent = shift_on ? moved : base;
      if (tag_on && err) ent[TAG_BIT] = 1'b1;
   end

endmodule

// File: rtl/cres_store.sv
module cres_store #(
   parameter int DEPTH = 4,
   parameter int ENT_W = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [ENT_W-1:0] wr_data,
   output logic [ENT_W-1:0] head,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr, wnext, rnext;

   generate
      if (DEPTH < 2) begin : g_chk_depth
         $error("cres_store: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_wrap
         assign wnext = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (push) wptr <= wnext;
         if (pop)  rptr <= rnext;
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign head  = mem[rptr];
   assign full  = (level == LVL_W'(DEPTH));
   assign empty = (level == '0);

   always_comb begin
      if (rst_n) AST_NO_OVERFLOW: assert (level <= LVL_W'(DEPTH)); // R5
   end

   AST_LVL_INC: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop |=> level == LVL_W'($past(level) + 1'b1)); // R2

   AST_LVL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      pop && !push |=> level == LVL_W'($past(level) - 1'b1)); // R2

   AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop |=> $stable(level)); // R11

endmodule

// File: rtl/cres_irq.sv
module cres_irq #(
   parameter int LVL_W = 3,
   parameter int THR_W = 4,
   localparam int CMP_W = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level,
   input  logic [THR_W-1:0] thr,
   input  logic             dreq_en,
   input  logic             ien,
   input  logic             ifrc,
   output logic             raw,
   output logic             masked,
   output logic             dma_req
);

   logic at_thr;

   assign at_thr  = CMP_W'(level) >= CMP_W'(thr);
   assign raw     = at_thr;
   assign masked  = (raw & ien) | ifrc;
   assign dma_req = dreq_en & at_thr;

   AST_FORCE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ifrc |-> masked); // R9

   AST_DREQ_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> raw); // R10

endmodule

// File: rtl/cres_fifo_ctrl.sv
module cres_fifo_ctrl
   import cres_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int SMP_W     = 16,
   parameter int RAW_W     = 12,
   parameter int SHIFT_AMT = 4,
   parameter int TAG_BIT   = 15,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5,
   localparam int ENT_W    = TAG_BIT + 1,
   localparam int LVL_W    = $clog2(DEPTH + 1),
   localparam int IDX_W    = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [SMP_W-1:0]  smp_data,
   input  logic              smp_err,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              dma_req,
   output logic              irq
);

   generate
      if (ADDR_W < 5) begin : g_chk_addr
         $error("cres_fifo_ctrl: ADDR_W must cover six word registers");
      end
      if (DATA_W < B_THR + FLD_W) begin : g_chk_data
         $error("cres_fifo_ctrl: DATA_W too narrow for control/status");
      end
      if (DEPTH > 15) begin : g_chk_lvl
         $error("cres_fifo_ctrl: level does not fit its 4-bit field");
      end
      if (ENT_W > DATA_W) begin : g_chk_ent
         $error("cres_fifo_ctrl: entry wider than data port");
      end
   endgenerate

   cfg_t             cfg_q;
   logic             over_q, under_q, ien_q, ifrc_q;
   logic [IDX_W-1:0] idx;
   logic             sel_ctrl, sel_data, sel_ien, sel_ifrc;
   logic             push_req, push, pop_req, pop;
   logic [ENT_W-1:0] ent_in, head;
   logic [LVL_W-1:0] level;
   logic             full, empty;
   logic             raw, masked;
   logic [DATA_W-1:0] ctrl_rd, rd_mux;
   logic             unused_wdata;

   assign idx      = reg_addr[ADDR_W-1:2];
   assign sel_ctrl = (idx == IDX_W'(RI_CTRL));
   assign sel_data = (idx == IDX_W'(RI_DATA));
   assign sel_ien  = (idx == IDX_W'(RI_IEN));
   assign sel_ifrc = (idx == IDX_W'(RI_IFRC));
   assign unused_wdata = ^{reg_addr[1:0], reg_wdata};

   // Push/pop qualification: decisions use the state before the edge
   assign push_req = smp_valid & cfg_q.en;
   assign push     = push_req & ~full;
   assign pop_req  = reg_rd & sel_data;
   assign pop      = pop_req & ~empty;

   cres_fmt #(
      .SMP_W(SMP_W), .RAW_W(RAW_W), .ENT_W(ENT_W),
      .SHIFT_AMT(SHIFT_AMT), .TAG_BIT(TAG_BIT)
   ) u_fmt (
      .smp(smp_data), .err(smp_err),
      .shift_on(cfg_q.shift), .tag_on(cfg_q.tag_en),
      .ent(ent_in)
   );

   cres_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .push(push), .pop(pop), .wr_data(ent_in),
      .head(head), .level(level), .full(full), .empty(empty)
   );

   cres_irq #(.LVL_W(LVL_W), .THR_W(FLD_W)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .level(level), .thr(cfg_q.thr), .dreq_en(cfg_q.dreq_en),
      .ien(ien_q), .ifrc(ifrc_q),
      .raw(raw), .masked(masked), .dma_req(dma_req)
   );

   assign irq = masked;

   // Configuration and sticky flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         over_q  <= 1'b0;
         under_q <= 1'b0;
         ien_q   <= 1'b0;
         ifrc_q  <= 1'b0;
      end else begin
         if (reg_wr && sel_ctrl) begin
            cfg_q.en      <= reg_wdata[B_EN];
            cfg_q.shift   <= reg_wdata[B_SHIFT];
            cfg_q.tag_en  <= reg_wdata[B_TAG];
            cfg_q.dreq_en <= reg_wdata[B_DREQ];
            cfg_q.thr     <= reg_wdata[B_THR +: FLD_W];
         end
         if (reg_wr && sel_ien)  ien_q  <= reg_wdata[0];
         if (reg_wr && sel_ifrc) ifrc_q <= reg_wdata[0];
         // set has priority over a same-cycle clear
         over_q  <= (push_req & full) |
                    (over_q & ~(reg_wr & sel_ctrl & reg_wdata[B_OVER]));
         under_q <= (pop_req & empty) |
                    (under_q & ~(reg_wr & sel_ctrl & reg_wdata[B_UNDER]));
      end
   end

   always_comb begin
      ctrl_rd                  = '0;
      ctrl_rd[B_EN]            = cfg_q.en;
      ctrl_rd[B_SHIFT]         = cfg_q.shift;
      ctrl_rd[B_TAG]           = cfg_q.tag_en;
      ctrl_rd[B_DREQ]          = cfg_q.dreq_en;
      ctrl_rd[B_EMPTY]         = empty;
      ctrl_rd[B_FULL]          = full;
      ctrl_rd[B_UNDER]         = under_q;
      ctrl_rd[B_OVER]          = over_q;
      ctrl_rd[B_LVL +: FLD_W]  = FLD_W'(level);
      ctrl_rd[B_THR +: FLD_W]  = cfg_q.thr;
   end

   always_comb begin
      rd_mux = '0;
      case (idx)
         IDX_W'(RI_CTRL): rd_mux = ctrl_rd;
         IDX_W'(RI_DATA): rd_mux = empty ? '0 : DATA_W'(head);
         IDX_W'(RI_RAW):  rd_mux = DATA_W'(raw);
         IDX_W'(RI_IEN):  rd_mux = DATA_W'(ien_q);
         IDX_W'(RI_IFRC): rd_mux = DATA_W'(ifrc_q);
         IDX_W'(RI_STAT): rd_mux = DATA_W'(masked);
         default:         rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   AST_UNDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd && sel_data && empty |=> reg_rdata == '0 && under_q); // R6

   AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid && cfg_q.en && full |=> over_q); // R5

   AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.en && !pop_req |=> $stable(level)); // R2

endmodule

// File: tb/tb_cres_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_cres_fifo_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_data = '0;
   logic        smp_err = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic        dma_req, irq;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   cres_fifo_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .smp_valid(smp_valid), .smp_data(smp_data), .smp_err(smp_err),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .dma_req(dma_req), .irq(irq)
   );

   localparam logic [4:0] A_CTRL = 5'h00, A_DATA = 5'h04, A_RAW = 5'h08,
                          A_IEN = 5'h0C, A_IFRC = 5'h10, A_STAT = 5'h14;

   // {ctrl[7:0], sample[15:0], err[7:0], expected[15:0]}
   localparam int NV = 7;
   localparam logic [47:0] VEC [NV] = '{
      {8'h01, 16'h0ABC, 8'h00, 16'h0ABC},   // R2 plain
      {8'h01, 16'hF123, 8'h00, 16'h0123},   // R2 mask to 12 bits
      {8'h03, 16'h0ABC, 8'h00, 16'h00AB},   // R3 shift
      {8'h05, 16'h0456, 8'h01, 16'h8456},   // R4 tagged
      {8'h01, 16'h0456, 8'h01, 16'h0456},   // R4 tag disabled
      {8'h07, 16'hFFFF, 8'h01, 16'h80FF},   // R3 R4 combined
      {8'h00, 16'h0111, 8'h00, 16'h0000}    // R2 disabled: nothing stored
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // all tasks start and end at a negedge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   task automatic push(input logic [15:0] d, input logic e);
      smp_data = d; smp_err = e; smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic push_pop(input logic [15:0] d, output logic [31:0] v);
      smp_data = d; smp_err = 1'b0; smp_valid = 1'b1;
      reg_addr = A_DATA; reg_rd = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0; reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v);       chk("R1 ctrl", v, 32'h0000_0100);
      chk("R1 dma_req", {31'b0, dma_req}, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);

      // Formatting vectors
      for (int i = 0; i < NV; i++) begin
         wr(A_CTRL, {24'h0, VEC[i][47:40]} | 32'h0000_0C00);
         push(VEC[i][39:24], VEC[i][16]);
         rd(A_DATA, v);
         chk($sformatf("R2/R3/R4 vector %0d", i), v, {16'h0, VEC[i][15:0]});
      end

      // R5 fill, full, overflow
      wr(A_CTRL, 32'h0000_0C01);
      push(16'h11, 0); push(16'h22, 0); push(16'h33, 0); push(16'h44, 0);
      rd(A_CTRL, v);       chk("R5 full level 4", v, 32'h0004_0201);
      push(16'h55, 0);
      rd(A_CTRL, v);       chk("R5 overflow", v, 32'h0004_0A01);
      rd(A_DATA, v);       chk("R2 order 1", v, 32'h11);
      rd(A_DATA, v);       chk("R2 order 2", v, 32'h22);
      rd(A_DATA, v);       chk("R2 order 3", v, 32'h33);
      rd(A_DATA, v);       chk("R5 drop keeps 4th", v, 32'h44);

      // R6 underflow
      rd(A_DATA, v);       chk("R6 empty read", v, 32'h0);
      rd(A_CTRL, v);       chk("R6 underflow flag", v, 32'h0000_0D01);

      // R7 write-one-to-clear
      wr(A_CTRL, 32'h0000_0801);
      rd(A_CTRL, v);       chk("R7 over cleared only", v, 32'h0000_0501);
      wr(A_CTRL, 32'h0000_0001);
      rd(A_CTRL, v);       chk("R7 zero keeps under", v, 32'h0000_0501);
      wr(A_CTRL, 32'h0000_0401);
      rd(A_CTRL, v);       chk("R7 under cleared", v, 32'h0000_0101);

      // R8 R9 R10 threshold 2 with DMA enabled
      wr(A_CTRL, 32'h0200_0009);
      rd(A_CTRL, v);       chk("R7 fields", v, 32'h0200_0109);
      push(16'h10, 0);
      rd(A_RAW, v);        chk("R8 below thr", v, 32'h0);
      chk("R10 below thr", {31'b0, dma_req}, 32'h0);
      push(16'h20, 0);
      rd(A_RAW, v);        chk("R8 at thr", v, 32'h1);
      chk("R10 at thr", {31'b0, dma_req}, 32'h1);
      chk("R9 masked off", {31'b0, irq}, 32'h0);
      wr(A_IEN, 32'hFFFF_FFFF);
      rd(A_IEN, v);        chk("R9 ien bit0 only", v, 32'h1);
      chk("R9 irq enabled", {31'b0, irq}, 32'h1);
      rd(A_STAT, v);       chk("R9 status", v, 32'h1);
      rd(A_DATA, v);       chk("R2 pop", v, 32'h10);
      chk("R10 after pop", {31'b0, dma_req}, 32'h0);
      chk("R9 after pop", {31'b0, irq}, 32'h0);
      wr(A_IFRC, 32'hFFFF_FFFF);
      rd(A_IFRC, v);       chk("R9 force bit0 only", v, 32'h1);
      chk("R9 forced irq", {31'b0, irq}, 32'h1);
      wr(A_IFRC, 32'h0);
      chk("R9 force cleared", {31'b0, irq}, 32'h0);
      wr(A_CTRL, 32'h0200_0001);
      push(16'h30, 0);
      chk("R10 dreq disabled", {31'b0, dma_req}, 32'h0);
      rd(A_RAW, v);        chk("R8 raw with dreq off", v, 32'h1);
      rd(A_DATA, v);       chk("R2 drain 1", v, 32'h20);
      rd(A_DATA, v);       chk("R2 drain 2", v, 32'h30);
      wr(A_CTRL, 32'h0000_0009);
      rd(A_RAW, v);        chk("R8 thr 0 empty", v, 32'h1);
      chk("R10 thr 0 empty", {31'b0, dma_req}, 32'h1);
      wr(A_IEN, 32'h0);

      // R11 simultaneous push and pop
      wr(A_CTRL, 32'h0000_0C01);
      push(16'hA1, 0); push(16'hA2, 0);
      push_pop(16'hA3, v); chk("R11 oldest", v, 32'hA1);
      rd(A_CTRL, v);       chk("R11 level kept", v, 32'h0002_0001);
      push(16'hA4, 0); push(16'hA5, 0);
      push_pop(16'hA6, v); chk("R11 full pop", v, 32'hA2);
      rd(A_CTRL, v);       chk("R11 full drop", v, 32'h0003_0801);
      rd(A_DATA, v);       chk("R11 rest 1", v, 32'hA3);
      rd(A_DATA, v);       chk("R11 rest 2", v, 32'hA4);
      rd(A_DATA, v);       chk("R11 rest 3", v, 32'hA5);
      rd(A_CTRL, v);       chk("R5 empty again", v, 32'h0000_0901);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule